// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides when the clocks of a small 8-bit microcontroller run. Software writes a power-control register over a simple register bus. One bit asks for a light sleep, in which only the CPU clock stops. Another bit asks for a deep sleep, in which the oscillator stops and every clock freezes. Two further bits are spare flags that software keeps for itself. The block drives three enables: one for the CPU clock, one for the peripheral clocks and one for the oscillator. It also reports the current mode on a two-bit status output.

Light sleep ends when an enabled interrupt request arrives. Deep sleep ends only on an external wake line or on a keypad line that is enabled and at its programmed level. This detection is level-sensitive and needs no clock. It raises the oscillator enable at once. The wake is then brought through a synchronizer, and the clocks stay gated for a fixed settling count before they run again. The asynchronous reset returns the block to normal run without waiting for a clock edge.

Top module: `pwr_mode_seq`

## Requirements
- R1: In run, a write to register 0 with bit 0 set and bit 1 clear enters light sleep from the next clock. In light sleep `cpu_clk_en` is 0, while `per_clk_en` and `osc_en` stay 1.
- R2: In run, a write to register 0 with bit 1 set enters deep sleep from the next clock, whatever bit 0 holds. In deep sleep both clock enables are 0 and `osc_en` is 0 until a wake is seen.
- R3: In light sleep, `irq_req` high at a clock edge returns the block to run at that edge, and bit 0 of register 0 then reads 0.
- R4: `rst` high sets run at once, without a clock edge. It clears register 0 to zero and clears register 1 to zero.
- R5: In deep sleep, a high level on either bit of `ext_wake` drives `osc_en` to 1 combinationally. The wake is held after the line drops.
- R6: In deep sleep, `irq_req`, a disabled keypad line, and an enabled keypad line at the opposite level do not wake the block. The mode stays 10 and `osc_en` stays 0.
- R7: After a wake, the mode stays 10 and both clock enables stay 0. Counting from the first clock edge at which the wake is held, the block returns to run, not to light sleep, on edge SYNC_STAGES+SETTLE_CYCLES+1. Both request bits then read 0.
- R8: Bits 3:2 of register 0 are free read/write flags. Entering or leaving either sleep mode does not change them. Register 0 reads as {0, flags, deep bit, light bit}.
- R9: Register 1 holds keypad wake enables in bits 7:4 and wake levels in bits 3:0. A level bit of 1 wakes on a high input and 0 wakes on a low input. The register reads back as written.
- R10: Bus writes to either register are ignored when the mode is not run.
- R11: `mode` reads 00 in run, 01 in light sleep, and 10 in deep sleep, including the settling period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 power control, 1 keypad wake setup |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register |
| irq_req | input | 1 | Any enabled interrupt is pending |
| ext_wake | input | 2 | External interrupt lines, active high |
| kbd_in | input | 4 | Keypad wake inputs |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| mode | output | 2 | Current mode code |

## Verification
The hardest case to reach is the wake from deep sleep. It begins with no clock edge, through the asynchronous set of the wake latch. It must then run the exact settling count while the wake pin may already be low again. To reach it, the stimulus puts the block into deep sleep and shows that interrupts and keypad lines that do not match are ignored. It then pulses a wake line for a single cycle, checks `osc_en` half a nanosecond later, and counts the edges until the CPU clock returns. A second pass wakes on a keypad line with low polarity, and a third on one with high polarity.

// File: rtl/pwr_mode_pkg.sv
`timescale 1ns/1ps
package pwr_mode_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'b00,
    ST_IDLE   = 2'b01,
    ST_DOWN   = 2'b10,
    ST_SETTLE = 2'b11
  } pstate_t;

  // a keypad line wakes when it is enabled and sits at its programmed level
  function automatic logic key_hit(input logic lvl, input logic pol, input logic en);
    return en & (lvl == pol);
  endfunction

  // settling counts as deep sleep on the status output
  function automatic logic [1:0] mode_code(input pstate_t s);
    logic [1:0] m;
    case (s)
      ST_RUN:  m = 2'b00;
      ST_IDLE: m = 2'b01;
      default: m = 2'b10;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/pwr_regs.sv
`timescale 1ns/1ps
module pwr_regs #(
  parameter int KEYS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              reg_sel,
  input  logic [2*KEYS-1:0] wr_data,
  output logic [1:0]        flags,
  output logic [KEYS-1:0]   kbd_pol,
  output logic [KEYS-1:0]   kbd_en
);
  logic wr_ctl, wr_kbd;
  assign wr_ctl = wr_ok & ~reg_sel;
  assign wr_kbd = wr_ok & reg_sel;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) flags <= '0;
    else if (wr_ctl) flags <= wr_data[3:2];
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      kbd_pol <= '0;
      kbd_en  <= '0;
    end else if (wr_kbd) begin
      kbd_pol <= wr_data[KEYS-1:0];
      kbd_en  <= wr_data[2*KEYS-1:KEYS];
    end
  end

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
    !wr_ctl |=> $stable(flags)); // R8
endmodule

// File: rtl/pwr_wake.sv
`timescale 1ns/1ps
module pwr_wake
  import pwr_mode_pkg::*;
#(
  parameter int KEYS        = 4,
  parameter int EXT         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            armed,
  input  logic            clr,
  input  logic [EXT-1:0]  ext_wake,
  input  logic [KEYS-1:0] kbd_in,
  input  logic [KEYS-1:0] kbd_pol,
  input  logic [KEYS-1:0] kbd_en,
  output logic            wake_src,
  output logic            wake_hold,
  output logic            wake_sync
);
  logic [KEYS-1:0]        key_hits;
  logic                   wake_set;
  logic [SYNC_STAGES-1:0] sync_q;

  for (genvar k = 0; k < KEYS; k++) begin : g_key
    assign key_hits[k] = key_hit(kbd_in[k], kbd_pol[k], kbd_en[k]);
  end

  assign wake_src = (|ext_wake) | (|key_hits);
  assign wake_set = armed & wake_src;

  // latches a wake without a running clock
  always_ff @(posedge clk or posedge rst or posedge wake_set) begin
    if (rst) wake_hold <= 1'b0;
    else if (wake_set) wake_hold <= 1'b1;
    else if (clr) wake_hold <= 1'b0;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sync_q <= '0;
    else if (clr) sync_q <= '0;
    else sync_q <= {sync_q[SYNC_STAGES-2:0], wake_hold};
  end
  assign wake_sync = sync_q[SYNC_STAGES-1];

  AST_SYNC_FOLLOWS_HOLD: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_sync) |-> wake_hold); // R5
endmodule

// File: rtl/pwr_fsm.sv
`timescale 1ns/1ps
module pwr_fsm
  import pwr_mode_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    ctl_wr,
  input  logic    req_idle,
  input  logic    req_down,
  input  logic    irq_req,
  input  logic    wake_sync,
  output pstate_t state,
  output logic    settle_done
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  pstate_t          nxt;
  logic [CNT_W-1:0] cnt_q;

  assign settle_done = (state == ST_SETTLE) && (cnt_q == LAST);

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:    if (ctl_wr) begin
                   if (req_down) nxt = ST_DOWN;
                   else if (req_idle) nxt = ST_IDLE;
                 end
      ST_IDLE:   if (irq_req) nxt = ST_RUN;
      ST_DOWN:   if (wake_sync) nxt = ST_SETTLE;
      default:   if (settle_done) nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) state <= ST_RUN;
    else state <= nxt;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) cnt_q <= '0;
    else if (state != ST_SETTLE) cnt_q <= '0;
    else if (!settle_done) cnt_q <= cnt_q + 1'b1;
  end

  AST_DOWN_NEEDS_WAKE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOWN && !wake_sync) |=> state == ST_DOWN); // R6
  AST_SETTLE_TO_RUN: assert property (@(posedge clk) disable iff (rst)
    settle_done |=> state == ST_RUN); // R7
  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |-> cnt_q <= LAST); // R7
endmodule

// File: rtl/pwr_mode_seq.sv
`timescale 1ns/1ps
module pwr_mode_seq
  import pwr_mode_pkg::*;
#(
  parameter int KEYS          = 4,
  parameter int EXT           = 2,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              reg_sel,
  input  logic [2*KEYS-1:0] wr_data,
  output logic [2*KEYS-1:0] rd_data,
  input  logic              irq_req,
  input  logic [EXT-1:0]    ext_wake,
  input  logic [KEYS-1:0]   kbd_in,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic [1:0]        mode
);
  localparam int DW = 2 * KEYS;

  pstate_t         state;
  logic            wr_ok, ctl_wr, settle_done;
  logic            wake_src, wake_hold, wake_sync;
  logic [1:0]      flags;
  logic [KEYS-1:0] kbd_pol, kbd_en;
  logic            bit_idle, bit_down;

  assign wr_ok  = wr_en & (state == ST_RUN);
  assign ctl_wr = wr_ok & ~reg_sel;

  pwr_regs #(.KEYS(KEYS)) u_regs (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .reg_sel(reg_sel), .wr_data(wr_data),
    .flags(flags), .kbd_pol(kbd_pol), .kbd_en(kbd_en)
  );

  pwr_wake #(.KEYS(KEYS), .EXT(EXT), .SYNC_STAGES(SYNC_STAGES)) u_wake (
    .clk(clk), .rst(rst), .armed(state == ST_DOWN), .clr(settle_done),
    .ext_wake(ext_wake), .kbd_in(kbd_in), .kbd_pol(kbd_pol), .kbd_en(kbd_en),
    .wake_src(wake_src), .wake_hold(wake_hold), .wake_sync(wake_sync)
  );

  pwr_fsm #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_fsm (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .req_idle(wr_data[0]),
    .req_down(wr_data[1]), .irq_req(irq_req), .wake_sync(wake_sync),
    .state(state), .settle_done(settle_done)
  );

  assign bit_idle   = (state == ST_IDLE);
  assign bit_down   = (state == ST_DOWN) || (state == ST_SETTLE);
  assign cpu_clk_en = (state == ST_RUN);
  assign per_clk_en = (state == ST_RUN) || (state == ST_IDLE);
  assign osc_en     = (state != ST_DOWN) | wake_hold;
  assign mode       = mode_code(state);
  assign rd_data    = reg_sel ? {kbd_en, kbd_pol}
                              : {{(DW-4){1'b0}}, flags, bit_down, bit_idle};

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && wr_en && !reg_sel && wr_data[0] && !wr_data[1])
      |=> (!cpu_clk_en && per_clk_en && osc_en)); // R1
  AST_DOWN_WINS: assert property (@(posedge clk) disable iff (rst)
    (cpu_clk_en && wr_en && !reg_sel && wr_data[1])
      |=> (!per_clk_en && mode == 2'b10)); // R2
  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && irq_req) |=> (cpu_clk_en && mode == 2'b00)); // R3
  AST_NO_WRITE_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    (!cpu_clk_en && wr_en) |=> ($stable(kbd_pol) && $stable(kbd_en))); // R10
  AST_SRC_OPENS_OSC: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && wake_src) |-> osc_en); // R5
endmodule

// File: tb/sim_pwr_mode_seq.sv
`timescale 1ns/100ps
module sim_pwr_mode_seq;
  localparam int NSET = 20;
  localparam int SYNC = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_req = 1'b0;
  logic [1:0] ext_wake = '0;
  logic [3:0] kbd_in = 4'b1110;
  logic       cpu_clk_en, per_clk_en, osc_en;
  logic [1:0] mode;

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;

  pwr_mode_seq #(.SYNC_STAGES(SYNC), .SETTLE_CYCLES(NSET)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel), .wr_data(wr_data),
    .rd_data(rd_data), .irq_req(irq_req), .ext_wake(ext_wake), .kbd_in(kbd_in),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en), .mode(mode)
  );

  initial forever #2 clk = ~clk;

  // reference model: 0 run, 1 light sleep, 2 deep sleep
  int       m_mode = 0;
  bit       m_lat = 1'b0;
  int       m_edges = 0;
  bit [1:0] m_flags = '0;
  bit [3:0] m_pol = '0;
  bit [3:0] m_en = '0;

  function automatic bit src_now();
    bit s = (ext_wake != 2'b00);
    for (int i = 0; i < 4; i++)
      if (m_en[i] && (kbd_in[i] == m_pol[i])) s = 1'b1;
    return s;
  endfunction

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      m_mode = 0; m_lat = 0; m_edges = 0; m_flags = '0; m_pol = '0; m_en = '0;
    end else begin
      case (m_mode)
        0: if (wr_en && !reg_sel) begin
             m_flags = wr_data[3:2];
             if (wr_data[1]) m_mode = 2;
             else if (wr_data[0]) m_mode = 1;
           end else if (wr_en && reg_sel) begin
             m_pol = wr_data[3:0];
             m_en  = wr_data[7:4];
           end
        1: if (irq_req) m_mode = 0;
        default: if (m_lat || src_now()) begin
             m_lat = 1'b1;
             m_edges++;
             if (m_edges == SYNC + 1 + NSET) begin
               m_mode = 0; m_lat = 0; m_edges = 0;
             end
           end
      endcase
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (running && !rst) begin
      chk("R1 cpu_clk_en", 32'(cpu_clk_en), 32'(m_mode == 0));
      chk("R2 per_clk_en", 32'(per_clk_en), 32'(m_mode != 2));
      chk("R5 osc_en", 32'(osc_en), 32'((m_mode != 2) || m_lat || src_now()));
      chk("R11 mode", 32'(mode), 32'(m_mode));
      chk("R8 rd_data", 32'(rd_data),
          reg_sel ? 32'({m_en, m_pol})
                  : 32'({4'b0, m_flags, m_mode == 2, m_mode == 1}));
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; reg_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_run(output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!cpu_clk_en && n < 200);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_up();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    running = 1'b1;
    tick();
    chk("R4 reset cpu_clk_en", 32'(cpu_clk_en), 32'd1);
    chk("R11 reset mode", 32'(mode), 32'd0);
    chk("R4 reset rd_data", 32'(rd_data), 32'd0);

    // keypad setup: keys 0,1 enabled; key0 wakes high, key1 wakes low
    bus_wr(1'b1, 8'h31);
    reg_sel = 1'b1;
    tick();
    chk("R9 keypad setup readback", 32'(rd_data), 32'h31);

    // light sleep with flags = 2'b10
    bus_wr(1'b0, 8'h09);
    chk("R1 light sleep cpu gated", 32'(cpu_clk_en), 32'd0);
    chk("R1 light sleep per running", 32'(per_clk_en), 32'd1);
    chk("R11 light sleep code", 32'(mode), 32'd1);
    bus_wr(1'b1, 8'hFF);
    reg_sel = 1'b1;
    tick();
    chk("R10 keypad write ignored asleep", 32'(rd_data), 32'h31);
    bus_wr(1'b0, 8'h02);
    chk("R10 control write ignored asleep", 32'(mode), 32'd1);
    irq_req = 1'b1;
    tick();
    irq_req = 1'b0;
    reg_sel = 1'b0;
    #0.5;
    chk("R3 irq ends light sleep", 32'(cpu_clk_en), 32'd1);
    chk("R8 flags kept over light sleep", 32'(rd_data), 32'h08);

    // asynchronous reset in light sleep
    bus_wr(1'b0, 8'h01);
    @(posedge clk);
    #1 rst = 1'b1;
    #0.5;
    chk("R4 async reset restores cpu clock", 32'(cpu_clk_en), 32'd1);
    chk("R4 async reset mode", 32'(mode), 32'd0);
    tick();
    rst = 1'b0;
    tick();
    bus_wr(1'b1, 8'h31);

    // deep sleep with both request bits, flags = 2'b01
    bus_wr(1'b0, 8'h07);
    chk("R2 deep sleep wins", 32'(mode), 32'd2);
    chk("R2 deep sleep osc off", 32'(osc_en), 32'd0);
    chk("R2 deep sleep readback", 32'(rd_data), 32'h06);
    irq_req = 1'b1;
    repeat (5) tick();
    irq_req = 1'b0;
    chk("R6 irq does not end deep sleep", 32'(mode), 32'd2);
    kbd_in = 4'b0010;
    tick();
    chk("R6 mismatched keys ignored", 32'(osc_en), 32'd0);
    ext_wake = 2'b10;
    #0.5;
    chk("R5 ext line opens oscillator", 32'(osc_en), 32'd1);
    #0.5;
    tick();
    ext_wake = 2'b00;
    kbd_in = 4'b1110;
    #0.5;
    chk("R5 wake held after pulse", 32'(osc_en), 32'd1);
    wait_run(n);
    chk("R7 settle edge count", 32'(n + 1), 32'(SYNC + NSET + 1));
    chk("R7 back in run", 32'(mode), 32'd0);
    chk("R8 flags kept over deep sleep", 32'(rd_data), 32'h04);

    // low-polarity keypad wake on key1
    bus_wr(1'b0, 8'h02);
    kbd_in = 4'b1100;
    #0.5;
    chk("R9 low level key wakes", 32'(osc_en), 32'd1);
    wait_run(n);
    kbd_in = 4'b1110;
    chk("R7 run after key wake", 32'(mode), 32'd0);

    // disabled keys ignored, then high-polarity key0 wakes
    bus_wr(1'b0, 8'h02);
    kbd_in = 4'b0010;
    repeat (3) tick();
    chk("R6 disabled keys ignored", 32'(osc_en), 32'd0);
    kbd_in = 4'b0011;
    #0.5;
    chk("R9 high level key wakes", 32'(osc_en), 32'd1);
    wait_run(n);
    kbd_in = 4'b1110;
    chk("R7 run after high key wake", 32'(cpu_clk_en), 32'd1);

    repeat (3) tick();
    running = 1'b0;
    finish_up();
  end
endmodule